// File: doc/BRIEF.md
# Receive FIFO with Ageing Timeout

This block is the receive side buffer of a serial port. A bit-level deserializer hands it one character per strobe, with parity and framing error tags, or signals a line break. Each accepted event becomes one entry in a 32-deep first-in first-out store. A bus read of the receive data register pops the oldest entry. The read word carries the character, its error tags and a valid marker. The block keeps three flags. Receive-ready reports that the fill level has reached a programmable trigger level. Data-ready reports that at least one entry is held, and receive-empty is its inverse.

An ageing timer covers a small number of characters left waiting below the trigger level, which would otherwise raise no ready flag. The timer runs only while the buffer holds data and receive-ready is clear, and every push or pop restarts it. After eight character times at the configured bit rate it sets a sticky ageing flag. Overrun and break-detected are also sticky, and each sticky flag has its own clear strobe. DEPTH must be a power of two.

Top module: `rx_age_fifo`

## Requirements
- R1: `rx_accept` is high exactly when `rx_en` is high and `fill_level` is below DEPTH (32).
- R2: Entries are read back in arrival order. The read word has bit 15 = valid marker (1), bit 14 = error summary (set when any of bits 13..10 is set), bit 13 = overrun, bit 12 = framing error, bit 11 = break, bit 10 = parity error, bits 9..8 = 0 and bits 7..0 = character. A pop takes effect at the clock edge on which `rd_pop` is high.
- R3: A character or break that arrives while 32 entries are held is discarded. The contents and the fill level stay unchanged, and `overrun_sts` is set.
- R4: An entry pushed while 31 entries are already held is stored with bits 14 and 13 set in addition to its own tags.
- R5: After a push, `rx_ready` is set if the new fill level is at least `trig_level`; it is never cleared by a push. `data_ready` goes high and `rx_empty` goes low.
- R6: After a pop, `rx_ready` clears if the remaining level is below `trig_level`; it is never set by a pop. When the level reaches zero, `data_ready` clears and `rx_empty` sets.
- R7: With the buffer empty, `rd_data` is zero, and a pop changes no flag and no level.
- R8: The ageing timer runs only while `rx_ready` is low and the buffer is non-empty. Every push or pop restarts it from zero. It sets sticky `ageing_sts` exactly AGE = (CLK_HZ / BAUD_HZ, integer division) × BITS_PER_CHAR × AGE_CHARS clock edges after the restarting edge. It then stays idle until the next push or pop.
- R9: A break (`in_break`, which wins over `in_valid` in the same cycle) pushes an entry with character 0 and bits 14, 12 and 11 set, and sets `break_sts`.
- R10: While `rx_en` is low, `in_valid` and `in_break` are ignored: no entry, no flag change.
- R11: `fifo_clear` empties the buffer (level 0, `rx_ready` low, `data_ready` low, `rx_empty` high) and stops the ageing timer. It takes priority over a push or pop in the same cycle. The sticky flags keep their values.
- R12: `clr_overrun`, `clr_break` and `clr_ageing` each clear their sticky flag. A set event in the same cycle wins over the clear.
- R13: After reset, the level is 0, `rx_empty` is 1, `rx_ready`, `data_ready` and all sticky flags are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception enable |
| in_valid | input | 1 | Character strobe from the deserializer |
| in_char | input | 8 | Received character |
| in_parity_err | input | 1 | Parity error tag for `in_char` |
| in_frame_err | input | 1 | Framing error tag for `in_char` |
| in_break | input | 1 | Line break event |
| rx_accept | output | 1 | Buffer can take a new character |
| rd_pop | input | 1 | Bus read of the receive data register |
| rd_data | output | 16 | Head entry word, zero when empty |
| trig_level | input | 6 | Receive trigger level |
| fifo_clear | input | 1 | Empty the buffer and stop the timer |
| clr_overrun | input | 1 | Clear `overrun_sts` |
| clr_break | input | 1 | Clear `break_sts` |
| clr_ageing | input | 1 | Clear `ageing_sts` |
| fill_level | output | 6 | Number of entries held |
| rx_ready | output | 1 | Fill level reached the trigger level |
| data_ready | output | 1 | At least one entry held |
| rx_empty | output | 1 | No entry held |
| overrun_sts | output | 1 | Sticky overrun |
| break_sts | output | 1 | Sticky break detected |
| ageing_sts | output | 1 | Sticky ageing timeout |

## Verification
The bench fills the buffer to exactly 31, 32 and 33 pushes. A design off by one in the last-slot test would tag the wrong entry or none. One that stored the 33rd character would overwrite the head or return an extra word, and one that missed the overrun would leave `overrun_sts` low. The ageing timer is timed to the exact edge, and a second push shortly before expiry must postpone it. It must stay silent while `rx_ready` holds it off and after a clear, so a timer that free-ran or ignored restarts would fire early or spuriously. Trigger boundaries (level equal to, and one below, the threshold), a pop on an empty buffer, a break together with a character, and a clear or sticky clear that collides with a push catch designs that get flag ordering or priority wrong.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CHAR_W     = 8;
  localparam int WORD_W     = 16;
  localparam int NUM_STICKY = 3;
  localparam int IDX_OVR    = 0;
  localparam int IDX_BRK    = 1;
  localparam int IDX_AGE    = 2;

  // One stored entry: tags above the character
  typedef struct packed {
    logic              err;
    logic              ovr;
    logic              frm;
    logic              brk;
    logic              par;
    logic [CHAR_W-1:0] ch;
  } rxq_entry_t;

  // Build an entry from deserializer inputs; a break carries no character
  function automatic rxq_entry_t make_entry(logic [CHAR_W-1:0] ch, logic par,
                                            logic frm, logic brk);
    rxq_entry_t e;
    e.ch  = brk ? '0 : ch;
    e.par = par & ~brk;
    e.frm = frm | brk;
    e.brk = brk;
    e.ovr = 1'b0;
    e.err = e.par | e.frm | e.brk;
    return e;
  endfunction

  // The entry that fills the final slot is marked as an overrun warning
  function automatic rxq_entry_t tag_last_slot(rxq_entry_t e, logic last);
    rxq_entry_t t;
    t = e;
    if (last) begin
      t.ovr = 1'b1;
      t.err = 1'b1;
    end
    return t;
  endfunction

  // Read word layout: valid marker on top, two zero bits before the char
  function automatic logic [WORD_W-1:0] to_word(rxq_entry_t e);
    return {1'b1, e.err, e.ovr, e.frm, e.brk, e.par, 2'b00, e.ch};
  endfunction

  // Ageing window in clock cycles
  function automatic int age_cycles(int clk_hz, int baud_hz, int bits, int chars);
    return (clk_hz / baud_hz) * bits * chars;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store import rxq_pkg::*; #(
  parameter  int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push_req,
  input  rxq_entry_t       wr_entry,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             push_drop,
  output logic             pop_ok,
  output logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] level_next,
  output rxq_entry_t       head
);

  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             full;
  logic             empty;

  assign full      = (level == CNT_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = push_req & ~clear & ~full;
  assign push_drop = push_req & ~clear & full;
  assign pop_ok    = pop_req & ~clear & ~empty;
  assign head      = mem[rd_ptr];

  always_comb begin
    level_next = level;
    if (clear) begin
      level_next = '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   level_next = level + CNT_W'(1);
        2'b01:   level_next = level - CNT_W'(1);
        default: level_next = level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      level <= level_next;
      if (clear) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
        if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_entry;
  end

  // R3: level never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  // R3: a discarded push leaves the buffer full
  p_drop_holds_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok) |=> (level == CNT_W'(DEPTH)));

  // R7: popping an empty buffer leaves it empty
  p_empty_pop_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && level == '0 && !push_req) |=> (level == '0));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags import rxq_pkg::*; #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push_ok,
  input  logic             push_drop,
  input  logic             pop_ok,
  input  logic             brk_evt,
  input  logic             age_fire,
  input  logic [CNT_W-1:0] level_next,
  input  logic [CNT_W-1:0] trig,
  input  logic             clr_ovr,
  input  logic             clr_brk,
  input  logic             clr_age,
  output logic             rx_ready,
  output logic             data_ready,
  output logic             rx_empty,
  output logic             ovr_sts,
  output logic             brk_sts,
  output logic             age_sts
);

  logic                  push_any;
  logic                  at_trig;
  logic [NUM_STICKY-1:0] st_set;
  logic [NUM_STICKY-1:0] st_clr;
  logic [NUM_STICKY-1:0] st_q;

  assign push_any = push_ok | push_drop;
  assign at_trig  = (level_next >= trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready   <= 1'b0;
      data_ready <= 1'b0;
      rx_empty   <= 1'b1;
    end else if (clear) begin
      rx_ready   <= 1'b0;
      data_ready <= 1'b0;
      rx_empty   <= 1'b1;
    end else begin
      if (push_any && pop_ok) begin
        rx_ready <= at_trig;
      end else if (push_any) begin
        if (at_trig) rx_ready <= 1'b1;
      end else if (pop_ok) begin
        if (!at_trig) rx_ready <= 1'b0;
      end
      if (push_any) begin
        data_ready <= 1'b1;
        rx_empty   <= 1'b0;
      end else if (pop_ok && level_next == '0) begin
        data_ready <= 1'b0;
        rx_empty   <= 1'b1;
      end
    end
  end

  assign st_set[IDX_OVR] = push_drop;
  assign st_set[IDX_BRK] = brk_evt;
  assign st_set[IDX_AGE] = age_fire;
  assign st_clr[IDX_OVR] = clr_ovr;
  assign st_clr[IDX_BRK] = clr_brk;
  assign st_clr[IDX_AGE] = clr_age;

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= 1'b0;
      else if (st_set[g]) q <= 1'b1;
      else if (st_clr[g]) q <= 1'b0;
    end
    assign st_q[g] = q;
  end

  assign ovr_sts = st_q[IDX_OVR];
  assign brk_sts = st_q[IDX_BRK];
  assign age_sts = st_q[IDX_AGE];

  // R3: a discarded push raises overrun
  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovr_sts);

  // R9: an accepted break raises break status
  p_break_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_sts);

  // R8: timer expiry is recorded
  p_age_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    age_fire |=> age_sts);

  // R5: data-ready and empty are always opposite
  p_ready_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready != rx_empty);

endmodule

// File: rtl/rxq_age_timer.sv
module rxq_age_timer #(
  parameter  int AGE_CYCLES = 8,
  localparam int AGE_W      = $clog2(AGE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic restart,
  input  logic rx_ready,
  input  logic rx_empty,
  output logic age_fire
);

  localparam logic [AGE_W-1:0] LAST = AGE_W'(AGE_CYCLES - 1);

  logic [AGE_W-1:0] cnt;
  logic             armed;
  logic             run;

  assign run      = armed & ~rx_ready & ~rx_empty;
  assign age_fire = run & (cnt == LAST) & ~restart & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (run) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt + AGE_W'(1);
      end
    end
  end

  // R8: no expiry on the cycle following a restart
  p_quiet_after_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && AGE_CYCLES > 1) |=> !age_fire);

  // R11: a clear silences the timer
  p_quiet_after_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !age_fire);

endmodule

// File: rtl/rx_age_fifo.sv
module rx_age_fifo import rxq_pkg::*; #(
  parameter  int DEPTH         = 32,
  parameter  int CLK_HZ        = 125_000_000,
  parameter  int BAUD_HZ       = 115_200,
  parameter  int BITS_PER_CHAR = 10,
  parameter  int AGE_CHARS     = 8,
  localparam int CNT_W         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_parity_err,
  input  logic              in_frame_err,
  input  logic              in_break,
  output logic              rx_accept,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic              fifo_clear,
  input  logic              clr_overrun,
  input  logic              clr_break,
  input  logic              clr_ageing,
  output logic [CNT_W-1:0]  fill_level,
  output logic              rx_ready,
  output logic              data_ready,
  output logic              rx_empty,
  output logic              overrun_sts,
  output logic              break_sts,
  output logic              ageing_sts
);

  localparam int AGE_CYCLES = age_cycles(CLK_HZ, BAUD_HZ, BITS_PER_CHAR, AGE_CHARS);

  logic             chr_take;
  logic             brk_take;
  logic             push_req;
  logic             brk_evt;
  logic             last_slot;
  rxq_entry_t       base_entry;
  rxq_entry_t       wr_entry;
  rxq_entry_t       head;
  logic             push_ok;
  logic             push_drop;
  logic             pop_ok;
  logic [CNT_W-1:0] level;
  logic [CNT_W-1:0] level_next;
  logic             age_fire;
  logic             age_restart;

  // Intake: a break takes precedence over a character strobe
  assign brk_take   = rx_en & in_break;
  assign chr_take   = rx_en & in_valid & ~in_break;
  assign push_req   = brk_take | chr_take;
  assign brk_evt    = brk_take & ~fifo_clear;
  assign last_slot  = (level == CNT_W'(DEPTH - 1));
  assign base_entry = make_entry(in_char, in_parity_err, in_frame_err, brk_take);
  assign wr_entry   = tag_last_slot(base_entry, last_slot);

  assign age_restart = push_ok | push_drop | pop_ok;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (fifo_clear),
    .push_req   (push_req),
    .wr_entry   (wr_entry),
    .pop_req    (rd_pop),
    .push_ok    (push_ok),
    .push_drop  (push_drop),
    .pop_ok     (pop_ok),
    .level      (level),
    .level_next (level_next),
    .head       (head)
  );

  rxq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (fifo_clear),
    .push_ok    (push_ok),
    .push_drop  (push_drop),
    .pop_ok     (pop_ok),
    .brk_evt    (brk_evt),
    .age_fire   (age_fire),
    .level_next (level_next),
    .trig       (trig_level),
    .clr_ovr    (clr_overrun),
    .clr_brk    (clr_break),
    .clr_age    (clr_ageing),
    .rx_ready   (rx_ready),
    .data_ready (data_ready),
    .rx_empty   (rx_empty),
    .ovr_sts    (overrun_sts),
    .brk_sts    (break_sts),
    .age_sts    (ageing_sts)
  );

  rxq_age_timer #(.AGE_CYCLES(AGE_CYCLES)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (fifo_clear),
    .restart  (age_restart),
    .rx_ready (rx_ready),
    .rx_empty (rx_empty),
    .age_fire (age_fire)
  );

  assign rx_accept  = rx_en & (level != CNT_W'(DEPTH));
  assign rd_data    = (level == '0) ? '0 : to_word(head);
  assign fill_level = level;

  // R6: empty flag agrees with the stored level
  p_empty_tracks_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty == (level == '0));

  // R7: empty buffer reads as zero
  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rd_data == '0));

  // R1: no acceptance while reception is off
  p_accept_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_accept);

endmodule

// File: tb/test_rx_age_fifo.sv
`timescale 1ns/1ps
module test_rx_age_fifo;

  localparam int TB_CLK_HZ = 1_000_000;
  localparam int TB_BAUD   = 100_000;
  localparam int T_AGE     = (TB_CLK_HZ / TB_BAUD) * 80;  // 10 bits x 8 chars

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = '0;
  logic        in_parity_err = 1'b0;
  logic        in_frame_err = 1'b0;
  logic        in_break = 1'b0;
  logic        rx_accept;
  logic        rd_pop = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  trig_level = 6'd4;
  logic        fifo_clear = 1'b0;
  logic        clr_overrun = 1'b0;
  logic        clr_break = 1'b0;
  logic        clr_ageing = 1'b0;
  logic [5:0]  fill_level;
  logic        rx_ready, data_ready, rx_empty;
  logic        overrun_sts, break_sts, ageing_sts;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_age_fifo #(
    .DEPTH(32), .CLK_HZ(TB_CLK_HZ), .BAUD_HZ(TB_BAUD),
    .BITS_PER_CHAR(10), .AGE_CHARS(8)
  ) i_rx_age_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_char(in_char), .in_parity_err(in_parity_err),
    .in_frame_err(in_frame_err), .in_break(in_break),
    .rx_accept(rx_accept), .rd_pop(rd_pop), .rd_data(rd_data),
    .trig_level(trig_level), .fifo_clear(fifo_clear),
    .clr_overrun(clr_overrun), .clr_break(clr_break),
    .clr_ageing(clr_ageing), .fill_level(fill_level),
    .rx_ready(rx_ready), .data_ready(data_ready), .rx_empty(rx_empty),
    .overrun_sts(overrun_sts), .break_sts(break_sts),
    .ageing_sts(ageing_sts)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_char(input logic [7:0] ch, input logic par, input logic frm);
    @(negedge clk);
    in_valid = 1'b1; in_char = ch; in_parity_err = par; in_frame_err = frm;
    @(negedge clk);
    in_valid = 1'b0; in_parity_err = 1'b0; in_frame_err = 1'b0;
  endtask

  task automatic pop_word(output logic [15:0] w);
    @(negedge clk);
    w = rd_data;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic pulse_clear_age();
    @(negedge clk); clr_ageing = 1'b1;
    @(negedge clk); clr_ageing = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13", "fill", fill_level, 0);
    chk("R13", "rx_empty", rx_empty, 1);
    chk("R13", "rx_ready", rx_ready, 0);
    chk("R13", "data_ready", data_ready, 0);
    chk("R13", "stickies", {overrun_sts, break_sts, ageing_sts}, 0);
    chk("R13", "rd_data", rd_data, 0);
    chk("R1", "accept while disabled", rx_accept, 0);
    rx_en = 1'b1;
    #1;
    chk("R1", "accept when enabled", rx_accept, 1);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    push_char(8'h5A, 1'b0, 1'b0);
    @(negedge clk); in_break = 1'b1;
    @(negedge clk); in_break = 1'b0;
    chk("R10", "fill", fill_level, 0);
    chk("R10", "rx_empty", rx_empty, 1);
    chk("R10", "break_sts", break_sts, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_order();
    logic [15:0] w;
    trig_level = 6'd4;
    push_char(8'h41, 1'b0, 1'b0);
    push_char(8'h42, 1'b1, 1'b0);
    push_char(8'h43, 1'b0, 1'b1);
    chk("R5", "fill", fill_level, 3);
    chk("R5", "rx_ready below trig", rx_ready, 0);
    chk("R5", "data_ready", data_ready, 1);
    chk("R5", "rx_empty", rx_empty, 0);
    pop_word(w); chk("R2", "word0", w, 16'h8041);
    pop_word(w); chk("R2", "word1 parity", w, 16'hC442);
    pop_word(w); chk("R2", "word2 framing", w, 16'hD043);
    chk("R6", "data_ready at zero", data_ready, 0);
    chk("R6", "rx_empty at zero", rx_empty, 1);
    pulse_clear_age();
  endtask

  task automatic t_trigger();
    logic [15:0] w;
    trig_level = 6'd2;
    push_char(8'h10, 1'b0, 1'b0);
    chk("R5", "ready at 1 of 2", rx_ready, 0);
    push_char(8'h11, 1'b0, 1'b0);
    chk("R5", "ready at 2 of 2", rx_ready, 1);
    push_char(8'h12, 1'b0, 1'b0);
    pop_word(w);
    chk("R6", "ready kept at level 2", rx_ready, 1);
    pop_word(w);
    chk("R6", "ready cleared at level 1", rx_ready, 0);
    pop_word(w);
    chk("R6", "last word", w, 16'h8012);
    pulse_clear_age();
  endtask

  task automatic t_empty_read();
    logic [15:0] w;
    chk("R7", "rd_data empty", rd_data, 0);
    pop_word(w);
    chk("R7", "empty read value", w, 0);
    chk("R7", "fill", fill_level, 0);
    chk("R7", "flags", {rx_ready, data_ready, rx_empty}, 3'b001);
  endtask

  task automatic t_full();
    logic [15:0] w;
    trig_level = 6'd32;
    for (int i = 0; i < 31; i++) push_char(8'(i), 1'b0, 1'b0);
    chk("R5", "ready at 31 of 32", rx_ready, 0);
    chk("R1", "accept at 31", rx_accept, 1);
    push_char(8'd31, 1'b0, 1'b0);
    chk("R1", "accept at 32", rx_accept, 0);
    chk("R5", "ready at 32", rx_ready, 1);
    chk("R3", "no overrun yet", overrun_sts, 0);
    push_char(8'hEE, 1'b0, 1'b0);
    chk("R3", "fill after drop", fill_level, 32);
    chk("R3", "overrun set", overrun_sts, 1);
    for (int i = 0; i < 32; i++) begin
      pop_word(w);
      if (i == 31) chk("R4", "last slot tagged", w, 16'hE01F);
      else         chk("R3", "drained word", w, 16'h8000 | 16'(i));
    end
    chk("R3", "empty after drain", rx_empty, 1);
    @(negedge clk); clr_overrun = 1'b1;
    @(negedge clk); clr_overrun = 1'b0;
    chk("R12", "overrun cleared", overrun_sts, 0);
    pulse_clear_age();
  endtask

  task automatic t_break();
    logic [15:0] w;
    trig_level = 6'd4;
    @(negedge clk);
    in_break = 1'b1; in_valid = 1'b1; in_char = 8'h55;
    @(negedge clk);
    in_break = 1'b0; in_valid = 1'b0;
    chk("R9", "single entry", fill_level, 1);
    chk("R9", "break_sts", break_sts, 1);
    pop_word(w);
    chk("R9", "break word", w, 16'hD800);
    @(negedge clk); clr_break = 1'b1;
    @(negedge clk); clr_break = 1'b0;
    chk("R12", "break cleared", break_sts, 0);
    pulse_clear_age();
  endtask

  task automatic t_ageing();
    logic [15:0] w;
    trig_level = 6'd4;
    push_char(8'h61, 1'b0, 1'b0);
    idle(T_AGE - 1);
    chk("R8", "not yet expired", ageing_sts, 0);
    idle(1);
    chk("R8", "expired on time", ageing_sts, 1);
    pop_word(w);
    pulse_clear_age();
    chk("R12", "ageing cleared", ageing_sts, 0);
    // restart postpones expiry
    push_char(8'h62, 1'b0, 1'b0);
    idle(T_AGE - 5);
    push_char(8'h63, 1'b0, 1'b0);
    idle(T_AGE - 1);
    chk("R8", "restart postponed", ageing_sts, 0);
    idle(1);
    chk("R8", "expired after restart", ageing_sts, 1);
    pop_word(w); pop_word(w);
    pulse_clear_age();
    // ready high holds the timer off
    trig_level = 6'd1;
    push_char(8'h64, 1'b0, 1'b0);
    idle(T_AGE + 10);
    chk("R8", "held off by ready", ageing_sts, 0);
    pop_word(w);
    idle(T_AGE + 10);
    chk("R8", "idle when empty", ageing_sts, 0);
  endtask

  task automatic t_clear();
    logic [15:0] w;
    trig_level = 6'd2;
    @(negedge clk); in_break = 1'b1;
    @(negedge clk); in_break = 1'b0;
    push_char(8'h71, 1'b0, 1'b0);
    chk("R11", "ready before clear", rx_ready, 1);
    @(negedge clk);
    fifo_clear = 1'b1; in_valid = 1'b1; in_char = 8'h72;
    @(negedge clk);
    fifo_clear = 1'b0; in_valid = 1'b0;
    chk("R11", "fill", fill_level, 0);
    chk("R11", "flags", {rx_ready, data_ready, rx_empty}, 3'b001);
    chk("R11", "sticky kept", break_sts, 1);
    chk("R11", "rd_data", rd_data, 0);
    idle(T_AGE + 5);
    chk("R11", "timer stopped", ageing_sts, 0);
    push_char(8'h73, 1'b0, 1'b0);
    pop_word(w);
    chk("R11", "fresh after clear", w, 16'h8073);
    // set wins over clear in the same cycle
    @(negedge clk); in_break = 1'b1; clr_break = 1'b1;
    @(negedge clk); in_break = 1'b0; clr_break = 1'b0;
    chk("R12", "set wins", break_sts, 1);
    pop_word(w);
    @(negedge clk); clr_break = 1'b1;
    @(negedge clk); clr_break = 1'b0;
    pulse_clear_age();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_order();
    t_trigger();
    t_empty_read();
    t_full();
    t_break();
    t_ageing();
    t_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule